// File: doc/BRIEF.md
# Debug Base-Address Read Trap Resolver

This block decides what happens when software reads the 64-bit debug base-address register through a coprocessor-style move. Two forms exist: a single-word read that returns the low 32 bits, and a two-word read that returns both halves. From the current exception level, the halted state and a set of trap control bits, the block selects one outcome:

- the read completes,
- the read is undefined,
- the read traps to a 64-bit handler at level 1, 2 or 3,
- the read raises a hypervisor trap for a 32-bit level 2.

For each outcome it also supplies the syndrome code and the read data.

The register image holds three things. Bits 47:12 carry the 4KB-aligned base of the debug table. Bits 1:0 carry a two-bit valid field. Every other bit reads as zero, and so does any address bit at or above the configured physical-address width.

Instruction decode and exception entry sit around the block. Each request takes one cycle to produce its response, which is held in an output register.

Top module: `dbg_base_read_gate`

## Requirements
- R1: The register image is laid out as follows. Bits 63:48 are zero and bits 11:2 are zero. Bits 47:12 are the table base input. Bits 1:0 are 2'b11 when the base-valid input is 1 and 2'b00 when it is 0.
- R2: Image bits at or above PA_BITS (default 40) read as zero, whatever the base input holds.
- R3: A single-word read (req_pair=0) puts image bits 31:0 on rsp_lo and zero on rsp_hi. A two-word read (req_pair=1) puts bits 31:0 on rsp_lo and bits 63:32 on rsp_hi.
- R4: Two conditions make the read succeed with no trap check at all: the core is halted with the ignore-traps option set, or the current level is 3.
- R5: A trap or hypervisor trap reports syndrome 8'h05 for the single-word form and 8'h0C for the two-word form. The one exception is the hypervisor trap caused by the user comms disable, which reports 8'h00.
- R6: At levels 0 to 2, one check comes before every other check. If the core is halted, level 3 is present and runs 64-bit, secure debug is disabled, the priority option is set and the level-3 debug trap bit is set, the read is undefined.
- R7: At level 0, the comms checks come next and take effect only when R6 does not apply.
  - If level 1 runs 64-bit and the user comms trap bit is set, the read traps to level 1. It traps to level 2 instead when level 2 is enabled, runs 64-bit and has the 64-bit general trap bit set.
  - If level 1 runs 32-bit and user comms disable is set, the read traps to a 64-bit level 2 that has its general trap bit set. Failing that, it raises a hypervisor trap (syndrome 8'h00) when level 2 is enabled, runs 32-bit and has its 32-bit general trap bit set. Otherwise the read is undefined.
- R8: Next, at levels 0 and 1, the read routes to an enabled level 2 when either level-2 debug trap bit is set. At level 0 only, the general trap bit of the matching view also causes this routing. The outcome is a trap to level 2 when level 2 runs 64-bit, and a hypervisor trap with the normal syndrome when it runs 32-bit.
- R9: Last, the read traps to level 3 when level 3 is present, runs 64-bit and has its debug trap bit set. It is undefined instead when the core is halted with secure debug disabled.
- R10: rsp_kind encodes the outcome as 0 read OK, 1 undefined, 2 trap, 3 hypervisor trap. rsp_target gives the target level for a trap and reads 2 for a hypervisor trap. For read OK and undefined, both rsp_target and rsp_syndrome are 0. When the outcome is not read OK, rsp_lo and rsp_hi are 0.
- R11: rsp_valid is high in the cycle after a cycle with req_valid high, and low in the cycle after a cycle with req_valid low.
- R12: Level-2 flags have no effect while level 2 is not enabled. Level-3 flags have no effect while level 3 is not present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request this cycle |
| req_pair | input | 1 | 1 = two-word read, 0 = single-word read |
| cur_el | input | 2 | Current exception level |
| halted | input | 1 | Core is in debug halt |
| ign_trap_dbg | input | 1 | Option: ignore traps while halted |
| el1_aa32 | input | 1 | Level 1 runs 32-bit |
| el2_aa32 | input | 1 | Level 2 runs 32-bit |
| el3_aa32 | input | 1 | Level 3 runs 32-bit |
| el2_on | input | 1 | Level 2 is enabled |
| el3_here | input | 1 | Level 3 is present |
| usr_cc_trap | input | 1 | User comms trap (64-bit level 1) |
| usr_cc_off | input | 1 | User comms disable (32-bit level 1) |
| gen_trap64 | input | 1 | General trap enable, 64-bit level-2 view |
| gen_trap32 | input | 1 | General trap enable, 32-bit level-2 view |
| l2_dbg_trap | input | 1 | Level-2 debug trap bit |
| l2_rom_trap | input | 1 | Level-2 debug-table trap bit |
| l3_dbg_trap | input | 1 | Level-3 debug trap bit |
| sec_dbg_off | input | 1 | Secure debug disabled |
| l3_prio_opt | input | 1 | Option: level-3 trap takes priority when halted |
| tbl_base | input | 36 | Table base address bits 47:12 |
| tbl_ok | input | 1 | Table base is valid |
| rsp_valid | output | 1 | Response valid |
| rsp_kind | output | 3 | Outcome code |
| rsp_target | output | 2 | Trap target level |
| rsp_syndrome | output | 8 | Syndrome code |
| rsp_lo | output | 32 | First destination word |
| rsp_hi | output | 32 | Second destination word |

## Verification
Every result is due exactly one cycle after its request: the outcome, target, syndrome and data all come out of a single output register. The bench drives a request on the falling edge and reads every output at the next falling edge. That edge lies half a period after the register captures and before the next request is applied. The rsp_valid check for an idle cycle follows the same one-cycle offset. The long randomized sweep keeps to it as well, comparing each response against the bench's own priority model.

// File: rtl/dbgrd_pkg.sv
package dbgrd_pkg;

  localparam int IMG_W   = 64;
  localparam int WORD_W  = 32;
  localparam int TBL_LSB = 12;
  localparam int TBL_MSB = 47;
  localparam int TBL_W   = TBL_MSB - TBL_LSB + 1;
  localparam int SYN_W   = 8;

  typedef enum logic [2:0] {
    RD_OK    = 3'd0,
    RD_UNDEF = 3'd1,
    RD_TRAP  = 3'd2,
    RD_HYP   = 3'd3
  } rd_kind_e;

  localparam logic [SYN_W-1:0] SYN_WORD  = 8'h05;
  localparam logic [SYN_W-1:0] SYN_PAIR  = 8'h0C;
  localparam logic [SYN_W-1:0] SYN_CC_HV = 8'h00;

  typedef struct packed {
    logic halted;
    logic ign_trap_dbg;
    logic el1_aa32;
    logic el2_aa32;
    logic el3_aa32;
    logic el2_on;
    logic el3_here;
    logic usr_cc_trap;
    logic usr_cc_off;
    logic gen_trap64;
    logic gen_trap32;
    logic l2_dbg_trap;
    logic l2_rom_trap;
    logic l3_dbg_trap;
    logic sec_dbg_off;
    logic l3_prio_opt;
  } trap_ctrl_t;

  typedef struct packed {
    rd_kind_e         kind;
    logic [1:0]       tgt;
    logic [SYN_W-1:0] syn;
  } rd_result_t;

endpackage

// File: rtl/dbgrd_trap_eval.sv
module dbgrd_trap_eval
  import dbgrd_pkg::*;
(
  input  logic [1:0] el,
  input  logic       pair,
  input  trap_ctrl_t c,
  output rd_result_t res
);

  logic             l3_64, l2_64, l2_32, l2_dbg;
  logic             early_undef, l3_hit, l3_block;
  logic             lvl0, below2;
  logic [SYN_W-1:0] syn_n;

  // Upper-level flags only count when that level is present / enabled (R12)
  assign l3_64       = c.el3_here & ~c.el3_aa32;
  assign l2_64       = c.el2_on & ~c.el2_aa32;
  assign l2_32       = c.el2_on & c.el2_aa32;
  assign l2_dbg      = c.l2_dbg_trap | c.l2_rom_trap;
  assign syn_n       = pair ? SYN_PAIR : SYN_WORD;
  assign lvl0        = (el == 2'd0);
  assign below2      = (el == 2'd0) || (el == 2'd1);
  assign early_undef = c.halted & l3_64 & c.sec_dbg_off & c.l3_prio_opt & c.l3_dbg_trap;
  assign l3_hit      = l3_64 & c.l3_dbg_trap;
  assign l3_block    = c.halted & c.sec_dbg_off;

  always_comb begin
    res = '{kind: RD_OK, tgt: 2'd0, syn: '0};
    if (c.halted && c.ign_trap_dbg) begin
      res.kind = RD_OK;                                   // debug bypass
    end else if (el == 2'd3) begin
      res.kind = RD_OK;                                   // top level always reads
    end else if (early_undef) begin
      res.kind = RD_UNDEF;                                // priority override
    end else if (lvl0 && !c.el1_aa32 && c.usr_cc_trap) begin
      res.kind = RD_TRAP;
      res.tgt  = (l2_64 && c.gen_trap64) ? 2'd2 : 2'd1;
      res.syn  = syn_n;
    end else if (lvl0 && c.el1_aa32 && c.usr_cc_off) begin
      if (l2_64 && c.gen_trap64) begin
        res.kind = RD_TRAP;
        res.tgt  = 2'd2;
        res.syn  = syn_n;
      end else if (l2_32 && c.gen_trap32) begin
        res.kind = RD_HYP;
        res.tgt  = 2'd2;
        res.syn  = SYN_CC_HV;
      end else begin
        res.kind = RD_UNDEF;
      end
    end else if (below2 && l2_64 && (l2_dbg || (lvl0 && c.gen_trap64))) begin
      res.kind = RD_TRAP;
      res.tgt  = 2'd2;
      res.syn  = syn_n;
    end else if (below2 && l2_32 && (l2_dbg || (lvl0 && c.gen_trap32))) begin
      res.kind = RD_HYP;
      res.tgt  = 2'd2;
      res.syn  = syn_n;
    end else if (l3_hit) begin
      if (l3_block) begin
        res.kind = RD_UNDEF;
      end else begin
        res.kind = RD_TRAP;
        res.tgt  = 2'd3;
        res.syn  = syn_n;
      end
    end
  end

endmodule

// File: rtl/dbgrd_image.sv
module dbgrd_image
  import dbgrd_pkg::*;
#(
  parameter int PA_BITS = 40
) (
  input  logic [TBL_W-1:0] base,
  input  logic             base_ok,
  output logic [IMG_W-1:0] img
);

  logic [TBL_W-1:0] base_m;

  // Address bits at or above the physical width read as zero (R2)
  for (genvar b = 0; b < TBL_W; b++) begin : g_mask
    if (b + TBL_LSB < PA_BITS) begin : g_keep
      assign base_m[b] = base[b];
    end else begin : g_zero
      assign base_m[b] = 1'b0;
    end
  end

  assign img = {{(IMG_W-TBL_MSB-1){1'b0}}, base_m,
                {(TBL_LSB-2){1'b0}}, {2{base_ok}}};

endmodule

// File: rtl/dbg_base_read_gate.sv
module dbg_base_read_gate
  import dbgrd_pkg::*;
#(
  parameter int PA_BITS = 40,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_pair,
  input  logic [1:0]             cur_el,
  input  logic                   halted,
  input  logic                   ign_trap_dbg,
  input  logic                   el1_aa32,
  input  logic                   el2_aa32,
  input  logic                   el3_aa32,
  input  logic                   el2_on,
  input  logic                   el3_here,
  input  logic                   usr_cc_trap,
  input  logic                   usr_cc_off,
  input  logic                   gen_trap64,
  input  logic                   gen_trap32,
  input  logic                   l2_dbg_trap,
  input  logic                   l2_rom_trap,
  input  logic                   l3_dbg_trap,
  input  logic                   sec_dbg_off,
  input  logic                   l3_prio_opt,
  input  logic [TBL_W-1:0]       tbl_base,
  input  logic                   tbl_ok,
  output logic                   rsp_valid,
  output logic [2:0]             rsp_kind,
  output logic [1:0]             rsp_target,
  output logic [SYN_W-1:0]       rsp_syndrome,
  output logic [WORD_W-1:0]      rsp_lo,
  output logic [WORD_W-1:0]      rsp_hi
);

  trap_ctrl_t        ctrl;
  rd_result_t        res;
  logic [IMG_W-1:0]  img;
  logic [WORD_W-1:0] nxt_lo, nxt_hi;
  logic              grant;

  assign ctrl = '{halted: halted, ign_trap_dbg: ign_trap_dbg,
                  el1_aa32: el1_aa32, el2_aa32: el2_aa32, el3_aa32: el3_aa32,
                  el2_on: el2_on, el3_here: el3_here,
                  usr_cc_trap: usr_cc_trap, usr_cc_off: usr_cc_off,
                  gen_trap64: gen_trap64, gen_trap32: gen_trap32,
                  l2_dbg_trap: l2_dbg_trap, l2_rom_trap: l2_rom_trap,
                  l3_dbg_trap: l3_dbg_trap, sec_dbg_off: sec_dbg_off,
                  l3_prio_opt: l3_prio_opt};

  dbgrd_trap_eval u_eval (
    .el   (cur_el),
    .pair (req_pair),
    .c    (ctrl),
    .res  (res)
  );

  dbgrd_image #(.PA_BITS(PA_BITS)) u_img (
    .base    (tbl_base),
    .base_ok (tbl_ok),
    .img     (img)
  );

  // Data only leaves the block on a granted read (R10); upper word for pairs (R3)
  assign grant  = (res.kind == RD_OK);
  assign nxt_lo = grant ? img[WORD_W-1:0] : '0;
  assign nxt_hi = (grant && req_pair) ? img[IMG_W-1:WORD_W] : '0;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rsp_valid <= 1'b0;
      end else begin
        rsp_valid <= req_valid;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rsp_kind     <= RD_OK;
        rsp_target   <= '0;
        rsp_syndrome <= '0;
        rsp_lo       <= '0;
        rsp_hi       <= '0;
      end else if (req_valid) begin
        rsp_kind     <= res.kind;
        rsp_target   <= res.tgt;
        rsp_syndrome <= res.syn;
        rsp_lo       <= nxt_lo;
        rsp_hi       <= nxt_hi;
      end
    end

    assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
    assert_idle_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
    assert_top_level_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cur_el == 2'd3) |=> (rsp_kind == RD_OK));
    assert_halt_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && halted && ign_trap_dbg) |=> (rsp_kind == RD_OK));
    assert_single_hi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_pair) |=> (rsp_hi == '0));
  end else begin : g_comb
    assign rsp_valid    = req_valid;
    assign rsp_kind     = res.kind;
    assign rsp_target   = res.tgt;
    assign rsp_syndrome = res.syn;
    assign rsp_lo       = nxt_lo;
    assign rsp_hi       = nxt_hi;
  end

  assert_no_data_on_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind != RD_OK) |-> (rsp_lo == '0 && rsp_hi == '0));
  assert_hyp_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RD_HYP) |-> (rsp_target == 2'd2));
  assert_trap_syndrome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RD_TRAP) |-> (rsp_syndrome == SYN_WORD || rsp_syndrome == SYN_PAIR));
  assert_kind_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind <= 3'd3));

endmodule

// File: tb/tb_dbg_base_read_gate.sv
`timescale 1ns/1ps
module tb_dbg_base_read_gate;

  localparam int PA = 40;
  // flag vector bit positions
  localparam int F_H = 0, F_IG = 1, F_A1 = 2, F_A2 = 3, F_A3 = 4, F_E2 = 5, F_E3 = 6;
  localparam int F_UT = 7, F_UD = 8, F_G64 = 9, F_G32 = 10, F_TD = 11, F_TR = 12;
  localparam int F_T3 = 13, F_SD = 14, F_PO = 15;
  localparam logic [2:0] K_OK = 3'd0, K_UN = 3'd1, K_TR = 3'd2, K_HV = 3'd3;

  logic clk, rst_n, req_valid, req_pair, tbl_ok;
  logic [1:0] cur_el;
  logic [15:0] fl;
  logic [35:0] tbl_base;
  logic rsp_valid;
  logic [2:0] rsp_kind;
  logic [1:0] rsp_target;
  logic [7:0] rsp_syndrome;
  logic [31:0] rsp_lo, rsp_hi;
  int checks = 0, errors = 0;
  bit done = 0;

  dbg_base_read_gate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pair(req_pair), .cur_el(cur_el),
    .halted(fl[F_H]), .ign_trap_dbg(fl[F_IG]), .el1_aa32(fl[F_A1]), .el2_aa32(fl[F_A2]),
    .el3_aa32(fl[F_A3]), .el2_on(fl[F_E2]), .el3_here(fl[F_E3]), .usr_cc_trap(fl[F_UT]),
    .usr_cc_off(fl[F_UD]), .gen_trap64(fl[F_G64]), .gen_trap32(fl[F_G32]),
    .l2_dbg_trap(fl[F_TD]), .l2_rom_trap(fl[F_TR]), .l3_dbg_trap(fl[F_T3]),
    .sec_dbg_off(fl[F_SD]), .l3_prio_opt(fl[F_PO]), .tbl_base(tbl_base), .tbl_ok(tbl_ok),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_target(rsp_target),
    .rsp_syndrome(rsp_syndrome), .rsp_lo(rsp_lo), .rsp_hi(rsp_hi));

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  function automatic logic [63:0] exp_img(input logic [35:0] b, input logic ok);
    logic [63:0] v = 64'h0;
    for (int i = 0; i < 36; i++) if (i + 12 < PA) v[i+12] = b[i];
    v[1:0] = ok ? 2'b11 : 2'b00;
    return v;
  endfunction

  // Behavioural model of the outcome chain, returns {kind, target, syndrome}
  function automatic logic [12:0] model(input logic [1:0] el, input logic pr, input logic [15:0] f);
    logic e2_64 = f[F_E2] && !f[F_A2];
    logic e2_32 = f[F_E2] && f[F_A2];
    logic e3_64 = f[F_E3] && !f[F_A3];
    logic [7:0] s = pr ? 8'h0C : 8'h05;
    if (f[F_H] && f[F_IG]) return {K_OK, 2'd0, 8'h00};
    if (el == 2'd3) return {K_OK, 2'd0, 8'h00};
    if (f[F_H] && e3_64 && f[F_SD] && f[F_PO] && f[F_T3]) return {K_UN, 2'd0, 8'h00};
    if (el == 2'd0) begin
      if (!f[F_A1] && f[F_UT]) return {K_TR, (e2_64 && f[F_G64]) ? 2'd2 : 2'd1, s};
      if (f[F_A1] && f[F_UD]) begin
        if (e2_64 && f[F_G64]) return {K_TR, 2'd2, s};
        if (e2_32 && f[F_G32]) return {K_HV, 2'd2, 8'h00};
        return {K_UN, 2'd0, 8'h00};
      end
      if (e2_64 && (f[F_G64] || f[F_TD] || f[F_TR])) return {K_TR, 2'd2, s};
      if (e2_32 && (f[F_G32] || f[F_TD] || f[F_TR])) return {K_HV, 2'd2, s};
    end else if (el == 2'd1) begin
      if (e2_64 && (f[F_TD] || f[F_TR])) return {K_TR, 2'd2, s};
      if (e2_32 && (f[F_TD] || f[F_TR])) return {K_HV, 2'd2, s};
    end
    if (e3_64 && f[F_T3]) begin
      if (f[F_H] && f[F_SD]) return {K_UN, 2'd0, 8'h00};
      return {K_TR, 2'd3, s};
    end
    return {K_OK, 2'd0, 8'h00};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge; response sampled one full cycle later at the next falling edge
  task automatic apply(input logic [1:0] el, input logic pr, input logic [15:0] f);
    @(negedge clk);
    req_valid = 1'b1; cur_el = el; req_pair = pr; fl = f;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [2:0] k, input logic [1:0] t, input logic [7:0] s);
    logic [63:0] im = exp_img(tbl_base, tbl_ok);
    logic [31:0] elo = (k == K_OK) ? im[31:0] : 32'h0;
    logic [31:0] ehi = (k == K_OK && req_pair) ? im[63:32] : 32'h0;
    chk({req, " outcome"}, {51'h0, rsp_valid, rsp_kind, rsp_target, rsp_syndrome},
        {51'h0, 1'b1, k, t, s});
    chk({req, " data"}, {rsp_hi, rsp_lo}, {ehi, elo});
  endtask

  function automatic logic [15:0] fs(input int a, input int b = -1, input int c = -1,
                                     input int d = -1, input int e = -1, input int g = -1);
    logic [15:0] v = '0;
    if (a >= 0) v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    if (d >= 0) v[d] = 1'b1;
    if (e >= 0) v[e] = 1'b1;
    if (g >= 0) v[g] = 1'b1;
    return v;
  endfunction

  task automatic t_reset();
    chk("R11 reset valid", {63'h0, rsp_valid}, 64'h0);
    chk("R10 reset outputs", {rsp_hi, rsp_lo}, 64'h0);
  endtask

  task automatic t_layout();
    tbl_base = '1; tbl_ok = 1'b1;
    apply(2'd3, 1'b1, '0);
    chk("R1 R2 pair image", {rsp_hi, rsp_lo}, 64'h0000_00FF_FFFF_F003);
    apply(2'd3, 1'b0, '0);
    chk("R3 single word", {rsp_hi, rsp_lo}, 64'h0000_0000_FFFF_F003);
    tbl_base = 36'h5_A5A5_A5A5; tbl_ok = 1'b0;
    apply(2'd3, 1'b1, '0);
    chk("R1 invalid field", {rsp_hi, rsp_lo}, exp_img(36'h5_A5A5_A5A5, 1'b0));
    chk("R2 upper zero", {32'h0, rsp_hi & 32'hFFFF_FF00}, 64'h0);
    tbl_ok = 1'b1;
  endtask

  task automatic t_always_ok();
    apply(2'd3, 1'b0, fs(F_E2, F_TD, F_E3, F_T3, F_UT, F_H));
    expect_out("R4 level3", K_OK, 2'd0, 8'h00);
    apply(2'd0, 1'b1, fs(F_H, F_IG, F_UT, F_E3, F_T3, F_SD));
    expect_out("R4 halted bypass", K_OK, 2'd0, 8'h00);
  endtask

  task automatic t_prio();
    apply(2'd0, 1'b0, fs(F_H, F_E3, F_SD, F_PO, F_T3, F_UT));
    expect_out("R6 early undef l0", K_UN, 2'd0, 8'h00);
    apply(2'd1, 1'b0, fs(F_H, F_E3, F_SD, F_PO, F_T3, F_E2) | fs(F_TD));
    expect_out("R6 early undef l1", K_UN, 2'd0, 8'h00);
    apply(2'd0, 1'b0, fs(F_UT));
    expect_out("R7 comms to l1", K_TR, 2'd1, 8'h05);
  endtask

  task automatic t_comms();
    apply(2'd0, 1'b0, fs(F_UT, F_E2, F_G64));
    expect_out("R7 comms to l2", K_TR, 2'd2, 8'h05);
    apply(2'd0, 1'b0, fs(F_A1, F_UD, F_E2, F_A2, F_G32));
    expect_out("R7 R5 hyp 00", K_HV, 2'd2, 8'h00);
    apply(2'd0, 1'b0, fs(F_A1, F_UD));
    expect_out("R7 undef", K_UN, 2'd0, 8'h00);
    apply(2'd0, 1'b1, fs(F_A1, F_UD, F_E2, F_G64));
    expect_out("R7 R5 pair trap", K_TR, 2'd2, 8'h0C);
  endtask

  task automatic t_l2_route();
    apply(2'd1, 1'b0, fs(F_E2, F_TD));
    expect_out("R8 l1 to l2", K_TR, 2'd2, 8'h05);
    apply(2'd1, 1'b1, fs(F_E2, F_A2, F_TR));
    expect_out("R8 R5 hyp pair", K_HV, 2'd2, 8'h0C);
    apply(2'd1, 1'b0, fs(F_E2, F_G64));
    expect_out("R8 general only at l0", K_OK, 2'd0, 8'h00);
    apply(2'd0, 1'b0, fs(F_E2, F_G64));
    expect_out("R8 l0 general", K_TR, 2'd2, 8'h05);
  endtask

  task automatic t_l3();
    apply(2'd2, 1'b0, fs(F_E3, F_T3));
    expect_out("R9 trap l3", K_TR, 2'd3, 8'h05);
    apply(2'd2, 1'b0, fs(F_E3, F_T3, F_H, F_SD));
    expect_out("R9 halted undef", K_UN, 2'd0, 8'h00);
    apply(2'd2, 1'b0, fs(F_E3, F_T3, F_A3));
    expect_out("R9 32-bit l3", K_OK, 2'd0, 8'h00);
  endtask

  task automatic t_ignored();
    apply(2'd0, 1'b1, fs(F_TD, F_TR, F_G64, F_G32));
    expect_out("R12 l2 disabled", K_OK, 2'd0, 8'h00);
    apply(2'd1, 1'b0, fs(F_T3, F_SD, F_PO, F_H));
    expect_out("R12 l3 absent", K_OK, 2'd0, 8'h00);
  endtask

  task automatic t_idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11 idle", {63'h0, rsp_valid}, 64'h0);
  endtask

  task automatic t_sweep();
    logic [31:0] r = 32'h1234_5678;
    for (int n = 0; n < 6000; n++) begin
      logic [12:0] m;
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      if (n % 16 == 0) begin tbl_base = {r[3:0], r}; tbl_ok = r[7]; end
      apply(r[1:0], r[2], r[18:3]);
      m = model(r[1:0], r[2], r[18:3]);
      expect_out("R5 R6 R7 R8 R9 sweep", m[12:10], m[9:8], m[7:0]);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_pair = 1'b0; cur_el = 2'd0; fl = '0;
    tbl_base = '0; tbl_ok = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_layout();
    t_always_ok();
    t_prio();
    t_comms();
    t_l2_route();
    t_l3();
    t_ignored();
    t_idle();
    t_sweep();
    t_idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule